// File: doc/BRIEF.md
# SIMT Reconvergence Stack Controller

This block tracks which thread lanes of one warp are enabled as the warp moves through data-dependent branches. Each cycle the core gives it the active lane mask of the instruction being issued, a per-lane predicate vector, the instruction's PC and at most one command strobe: split, join or branch. In the same cycle the block returns the lane mask for the next instruction, a PC redirect request with its target, and two fault flags.

A split whose active lanes all agree pushes one uniform entry that holds the current mask. A split whose active lanes disagree pushes two entries. The lower entry holds the full mask and is marked fall-through. The upper entry holds the predicate-true lanes and the resume PC, which is the address after the split. The predicate-false lanes then run first. Each join pops one entry and restores its mask. The PC is redirected only when the popped entry is neither uniform nor fall-through. The stack is updated on the clock edge, and only once per warp instruction.

Top module: `simt_reconv_stack`

## Requirements
- R1: On a branch command, divFault is 1 when the active predicate-true lanes (activeMask & predMask) are neither none nor all of the active lanes. nextMask equals activeMask.
- R2: On a split where every active lane has the same predicate (predicates of inactive lanes are ignored), one uniform entry holding activeMask is pushed. nextMask equals activeMask and no redirect is requested.
- R3: On a split with mixed active predicates, a fall-through entry holding activeMask is pushed, then a taken entry holding activeMask & predMask and the resume PC. nextMask is activeMask & ~predMask.
- R4: A join whose top entry is uniform drives nextMask to that entry's mask, pops it, and does not redirect.
- R5: A join whose top entry is a taken entry drives redirectValid with redirectPc equal to the split's PC plus PC_STEP (4 by default). It drives nextMask to the entry's mask and pops it.
- R6: A join whose top entry is a fall-through entry drives nextMask to the entry's mask, pops it, and does not redirect.
- R7: A split with activeMask all zero raises divFault, pushes nothing and leaves nextMask equal to activeMask.
- R8: A split that needs more free entries than remain (one for uniform, two for mixed, DEPTH=8) raises stackErr, leaves the stack unchanged, and drives nextMask equal to activeMask.
- R9: A join on an empty stack raises stackErr, does not redirect, and drives nextMask equal to activeMask.
- R10: After reset the stack is empty.
- R11: With no command, nextMask equals activeMask and redirectValid, divFault and stackErr are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdSplit | input | 1 | Split command for the current instruction |
| cmdJoin | input | 1 | Join command for the current instruction |
| cmdBranch | input | 1 | Control-flow instruction, checked for divergence |
| activeMask | input | LANES | Lanes enabled for the current instruction |
| predMask | input | LANES | Per-lane predicate values |
| curPc | input | PC_W | PC of the current instruction |
| nextMask | output | LANES | Lane mask for the next instruction |
| redirectValid | output | 1 | PC redirect requested |
| redirectPc | output | PC_W | Redirect target |
| divFault | output | 1 | Divergence fault |
| stackErr | output | 1 | Stack overflow or underflow |

## Verification
The bench builds the block with the defaults: four lanes, a depth of eight and a 32-bit PC. Four lanes give partial masks in which inactive lanes carry set predicates, so uniformity is judged only over the active lanes. A depth of eight can be filled in a few dozen cycles. That makes three boundary cases reachable: a mixed split with a single free entry, a uniform split on a full stack, and a join past the bottom of the stack.

// File: rtl/reconv_pkg.sv
package reconv_pkg;
  // Strobes from control to the stack datapath; at most one is high.
  typedef struct packed {
    logic pushUni;
    logic pushPair;
    logic pop;
  } stackCmd_t;
endpackage

// File: rtl/reconv_stack_dp.sv
module reconv_stack_dp
  import reconv_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int DEPTH   = 8,
  parameter int PC_W    = 32,
  parameter int PC_STEP = 4,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  stackCmd_t        cmd,
  input  logic [LANES-1:0] activeMask,
  input  logic [LANES-1:0] predMask,
  input  logic [PC_W-1:0]  curPc,
  output logic [CNT_W-1:0] depthCnt,
  output logic [LANES-1:0] topMask,
  output logic [PC_W-1:0]  topPc,
  output logic             topUniform,
  output logic             topFallThrough
);
  logic [LANES-1:0] maskMem [DEPTH];
  logic [PC_W-1:0]  pcMem   [DEPTH];
  logic             uniMem  [DEPTH];
  logic             ftMem   [DEPTH];

  logic [PC_W-1:0] resumePc;
  assign resumePc = curPc + PC_W'(PC_STEP);

  // Each slot decides for itself whether it is written this cycle.
  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        maskMem[g] <= '0;
        pcMem[g]   <= '0;
        uniMem[g]  <= 1'b0;
        ftMem[g]   <= 1'b0;
      end else if (cmd.pushUni && depthCnt == CNT_W'(g)) begin
        maskMem[g] <= activeMask;
        pcMem[g]   <= curPc;
        uniMem[g]  <= 1'b1;
        ftMem[g]   <= 1'b0;
      end else if (cmd.pushPair && depthCnt == CNT_W'(g)) begin
        maskMem[g] <= activeMask;
        pcMem[g]   <= curPc;
        uniMem[g]  <= 1'b0;
        ftMem[g]   <= 1'b1;
      end else if (cmd.pushPair && depthCnt + CNT_W'(1) == CNT_W'(g)) begin
        maskMem[g] <= activeMask & predMask;
        pcMem[g]   <= resumePc;
        uniMem[g]  <= 1'b0;
        ftMem[g]   <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             depthCnt <= '0;
    else if (cmd.pushUni)  depthCnt <= depthCnt + CNT_W'(1);
    else if (cmd.pushPair) depthCnt <= depthCnt + CNT_W'(2);
    else if (cmd.pop)      depthCnt <= depthCnt - CNT_W'(1);
  end

  always_comb begin
    topMask        = '0;
    topPc          = '0;
    topUniform     = 1'b0;
    topFallThrough = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (depthCnt == CNT_W'(i + 1)) begin
        topMask        = maskMem[i];
        topPc          = pcMem[i];
        topUniform     = uniMem[i];
        topFallThrough = ftMem[i];
      end
    end
  end
endmodule

// File: rtl/reconv_ctrl.sv
module reconv_ctrl
  import reconv_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int DEPTH  = 8,
  parameter int PC_W   = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             cmdSplit,
  input  logic             cmdJoin,
  input  logic             cmdBranch,
  input  logic [LANES-1:0] activeMask,
  input  logic [LANES-1:0] predMask,
  input  logic [CNT_W-1:0] depthCnt,
  input  logic [LANES-1:0] topMask,
  input  logic [PC_W-1:0]  topPc,
  input  logic             topUniform,
  input  logic             topFallThrough,
  output stackCmd_t        cmd,
  output logic [LANES-1:0] nextMask,
  output logic             redirectValid,
  output logic [PC_W-1:0]  redirectPc,
  output logic             divFault,
  output logic             stackErr
);
  logic [LANES-1:0] takenLanes;
  logic             anyActive, mixed, roomOne, roomTwo;

  assign takenLanes = activeMask & predMask;
  assign anyActive  = |activeMask;
  // The taken set is a subset of the active set, so a partial match is mixed.
  assign mixed      = (takenLanes != '0) && (takenLanes != activeMask);
  assign roomOne    = depthCnt < CNT_W'(DEPTH);
  assign roomTwo    = depthCnt < CNT_W'(DEPTH - 1);

  always_comb begin
    cmd           = '0;
    nextMask      = activeMask;
    redirectValid = 1'b0;
    redirectPc    = '0;
    divFault      = 1'b0;
    stackErr      = 1'b0;
    if (cmdSplit) begin
      if (!anyActive) begin
        divFault = 1'b1;
      end else if (!mixed) begin
        if (roomOne) cmd.pushUni = 1'b1;
        else         stackErr    = 1'b1;
      end else if (roomTwo) begin
        cmd.pushPair = 1'b1;
        nextMask     = activeMask & ~predMask;
      end else begin
        stackErr = 1'b1;
      end
    end else if (cmdJoin) begin
      if (depthCnt == '0) begin
        stackErr = 1'b1;
      end else begin
        cmd.pop  = 1'b1;
        nextMask = topMask;
        if (!topUniform && !topFallThrough) begin
          redirectValid = 1'b1;
          redirectPc    = topPc;
        end
      end
    end else if (cmdBranch) begin
      divFault = mixed;
    end
  end
endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
  import reconv_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int DEPTH   = 8,
  parameter int PC_W    = 32,
  parameter int PC_STEP = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdSplit,
  input  logic             cmdJoin,
  input  logic             cmdBranch,
  input  logic [LANES-1:0] activeMask,
  input  logic [LANES-1:0] predMask,
  input  logic [PC_W-1:0]  curPc,
  output logic [LANES-1:0] nextMask,
  output logic             redirectValid,
  output logic [PC_W-1:0]  redirectPc,
  output logic             divFault,
  output logic             stackErr
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  stackCmd_t        stackCmd;
  logic [CNT_W-1:0] depthCnt;
  logic [LANES-1:0] topMask;
  logic [PC_W-1:0]  topPc;
  logic             topUniform, topFallThrough;

  reconv_ctrl #(.LANES(LANES), .DEPTH(DEPTH), .PC_W(PC_W)) u_ctrl (
    .cmdSplit(cmdSplit), .cmdJoin(cmdJoin), .cmdBranch(cmdBranch),
    .activeMask(activeMask), .predMask(predMask), .depthCnt(depthCnt),
    .topMask(topMask), .topPc(topPc), .topUniform(topUniform),
    .topFallThrough(topFallThrough), .cmd(stackCmd), .nextMask(nextMask),
    .redirectValid(redirectValid), .redirectPc(redirectPc),
    .divFault(divFault), .stackErr(stackErr)
  );

  reconv_stack_dp #(.LANES(LANES), .DEPTH(DEPTH), .PC_W(PC_W), .PC_STEP(PC_STEP)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(stackCmd), .activeMask(activeMask),
    .predMask(predMask), .curPc(curPc), .depthCnt(depthCnt),
    .topMask(topMask), .topPc(topPc), .topUniform(topUniform),
    .topFallThrough(topFallThrough)
  );
endmodule

// File: rtl/simt_reconv_stack_checker.sv
module simt_reconv_stack_checker #(
  parameter int LANES = 4,
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdSplit,
  input logic             cmdJoin,
  input logic             cmdBranch,
  input logic [LANES-1:0] activeMask,
  input logic [LANES-1:0] predMask,
  input logic [LANES-1:0] nextMask,
  input logic             redirectValid,
  input logic             divFault,
  input logic             stackErr,
  input logic [CNT_W-1:0] depthCnt
);
  logic noCmd, uniformSplit;
  assign noCmd        = !cmdSplit && !cmdJoin && !cmdBranch;
  assign uniformSplit = cmdSplit && !cmdJoin && (activeMask != '0) &&
                        (((activeMask & predMask) == activeMask) || ((activeMask & predMask) == '0));

  assert_idle_passthru_R11: assert property (@(posedge clk) disable iff (!rstN)
    noCmd |-> (nextMask == activeMask) && !redirectValid && !divFault && !stackErr);

  assert_err_holds_mask_R9: assert property (@(posedge clk) disable iff (!rstN)
    stackErr |-> (nextMask == activeMask) && !redirectValid);

  assert_redirect_only_on_join_R5: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> cmdJoin);

  assert_split_no_new_lanes_R3: assert property (@(posedge clk) disable iff (!rstN)
    cmdSplit |-> ((nextMask & ~activeMask) == '0));

  assert_uniform_push_one_R2: assert property (@(posedge clk) disable iff (!rstN)
    (uniformSplit && !stackErr) |=> (depthCnt == $past(depthCnt) + CNT_W'(1)));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    depthCnt <= CNT_W'(DEPTH));

  assert_empty_split_fault_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdSplit && activeMask == '0) |=> $stable(depthCnt));

  assert_branch_idle_lanes_R1: assert property (@(posedge clk) disable iff (!rstN)
    (cmdBranch && !cmdSplit && !cmdJoin && activeMask == '0) |-> !divFault);
endmodule

bind simt_reconv_stack simt_reconv_stack_checker #(
  .LANES(LANES), .DEPTH(DEPTH), .CNT_W($clog2(DEPTH + 1))
) u_checker (
  .clk(clk), .rstN(rstN), .cmdSplit(cmdSplit), .cmdJoin(cmdJoin),
  .cmdBranch(cmdBranch), .activeMask(activeMask), .predMask(predMask),
  .nextMask(nextMask), .redirectValid(redirectValid), .divFault(divFault),
  .stackErr(stackErr), .depthCnt(depthCnt)
);

// File: tb/simt_reconv_stack_bench.sv
module simt_reconv_stack_bench;
  localparam int LANES = 4;
  localparam int PC_W  = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdSplit = 1'b0, cmdJoin = 1'b0, cmdBranch = 1'b0;
  logic [LANES-1:0] activeMask = '0, predMask = '0;
  logic [PC_W-1:0] curPc = '0;
  logic [LANES-1:0] nextMask;
  logic redirectValid, divFault, stackErr;
  logic [PC_W-1:0] redirectPc;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  simt_reconv_stack u_simt_reconv_stack (
    .clk(clk), .rstN(rstN), .cmdSplit(cmdSplit), .cmdJoin(cmdJoin),
    .cmdBranch(cmdBranch), .activeMask(activeMask), .predMask(predMask),
    .curPc(curPc), .nextMask(nextMask), .redirectValid(redirectValid),
    .redirectPc(redirectPc), .divFault(divFault), .stackErr(stackErr)
  );

  // {split, join, branch, act, pred, pc, expMask, expRedir, expPc, expFault, expErr}
  typedef struct packed {
    logic sp; logic jn; logic br;
    logic [3:0] act; logic [3:0] pred; logic [31:0] pc;
    logic [3:0] eMask; logic eRedir; logic [31:0] ePc; logic eFault; logic eErr;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{0,0,1, 4'hF,4'hF,32'h010, 4'hF,0,32'h0,0,0}, // R1 all taken
    '{0,0,1, 4'hF,4'h3,32'h014, 4'hF,0,32'h0,1,0}, // R1 divergent
    '{0,0,1, 4'hF,4'h0,32'h018, 4'hF,0,32'h0,0,0}, // R1 none taken
    '{0,0,1, 4'h6,4'h9,32'h01C, 4'h6,0,32'h0,0,0}, // R1 only inactive taken
    '{0,1,0, 4'hF,4'h0,32'h020, 4'hF,0,32'h0,0,1}, // R10 empty after reset
    '{1,0,0, 4'h7,4'hB,32'h100, 4'h4,0,32'h0,0,0}, // R3 mixed split
    '{1,0,0, 4'h4,4'h4,32'h200, 4'h4,0,32'h0,0,0}, // R2 uniform split
    '{0,1,0, 4'h4,4'h0,32'h204, 4'h4,0,32'h0,0,0}, // R4 uniform join
    '{0,1,0, 4'h4,4'h0,32'h208, 4'h3,1,32'h104,0,0}, // R5 taken join
    '{0,1,0, 4'h3,4'h0,32'h108, 4'h7,0,32'h0,0,0}, // R6 fall-through join
    '{0,1,0, 4'hF,4'h0,32'h10C, 4'hF,0,32'h0,0,1}, // R9 underflow
    '{1,0,0, 4'h0,4'hF,32'h110, 4'h0,0,32'h0,1,0}, // R7 no lanes active
    '{0,1,0, 4'h5,4'h0,32'h114, 4'h5,0,32'h0,0,1}, // R7 nothing was pushed
    '{1,0,0, 4'h3,4'hC,32'h118, 4'h3,0,32'h0,0,0}, // R2 inactive preds ignored
    '{0,0,0, 4'h9,4'h6,32'h11C, 4'h9,0,32'h0,0,0}  // R11 idle
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic j, input logic b,
                       input logic [3:0] a, input logic [3:0] p, input logic [31:0] pc);
    @(negedge clk);
    cmdSplit = s; cmdJoin = j; cmdBranch = b;
    activeMask = a; predMask = p; curPc = pc;
    #1;
  endtask

  task automatic expect_out(input string req, input logic [3:0] m, input logic r,
                            input logic [31:0] rp, input logic f, input logic e);
    check({req, " mask"}, 64'(nextMask), 64'(m));
    check({req, " redirect"}, 64'(redirectValid), 64'(r));
    if (r) check({req, " target"}, 64'(redirectPc), 64'(rp));
    check({req, " fault"}, 64'(divFault), 64'(f));
    check({req, " err"}, 64'(stackErr), 64'(e));
  endtask

  initial begin : watchdog
    #1000000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].sp, VECS[i].jn, VECS[i].br, VECS[i].act, VECS[i].pred, VECS[i].pc);
      expect_out($sformatf("vec%0d", i), VECS[i].eMask, VECS[i].eRedir,
                 VECS[i].ePc, VECS[i].eFault, VECS[i].eErr);
    end
    // Pop the uniform entry left by the last split.
    drive(0,1,0, 4'h3,4'h0,32'h120);
    expect_out("R4 pop", 4'h3, 0, 0, 0, 0);

    // Overflow boundaries (R8): reset, then fill seven slots.
    @(negedge clk); rstN = 1'b0; cmdSplit = 0; cmdJoin = 0; cmdBranch = 0;
    @(negedge clk); rstN = 1'b1;
    for (int k = 0; k < 7; k++) begin
      drive(1,0,0, 4'hF,4'hF,32'h300);
      expect_out("R2 fill", 4'hF, 0, 0, 0, 0);
    end
    drive(1,0,0, 4'hF,4'h1,32'h400);
    expect_out("R8 mixed needs two", 4'hF, 0, 0, 0, 1);
    drive(1,0,0, 4'hE,4'h0,32'h404);
    expect_out("R8 last uniform fits", 4'hE, 0, 0, 0, 0);
    drive(1,0,0, 4'h1,4'h1,32'h408);
    expect_out("R8 full", 4'h1, 0, 0, 0, 1);
    // Unwind: top is the 4'hE entry, then seven 4'hF entries.
    drive(0,1,0, 4'h2,4'h0,32'h40C);
    expect_out("R8 top intact", 4'hE, 0, 0, 0, 0);
    for (int k = 0; k < 7; k++) begin
      drive(0,1,0, 4'h1,4'h0,32'h410);
      expect_out("R4 unwind", 4'hF, 0, 0, 0, 0);
    end
    drive(0,1,0, 4'h8,4'h0,32'h414);
    expect_out("R9 drained", 4'h8, 0, 0, 0, 1);

    // Reset clears a non-empty stack (R10).
    drive(1,0,0, 4'hF,4'h5,32'h500);
    expect_out("R3 mixed again", 4'hA, 0, 0, 0, 0);
    @(negedge clk); rstN = 1'b0; cmdSplit = 0;
    @(negedge clk); rstN = 1'b1;
    drive(0,1,0, 4'hF,4'h0,32'h504);
    expect_out("R10 reset clears", 4'hF, 0, 0, 0, 1);

    drive(0,0,0, 4'h0,4'h0,32'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule